// File: doc/BRIEF.md
# Two-Way Latched/Registered Bus Transceiver

This block moves data between two parallel buses, A and B, through two independent storage paths: one from A to B and one from B to A. Each path has four controls of its own: an active-low output enable, a latch enable, a path clock and an active-low clock enable. Each path stores data in one element that acts in one of three ways. It passes data straight through while the latch enable is high. It holds its contents while the latch enable is low and the clock stays still. It loads the input on a rising clock edge when the latch enable is low and the clock enable is asserted.

Each bus side is modelled as a separate input vector, output vector and output-valid flag, so that both directions can run at once without contention. The output enable acts only on the drivers. Storage keeps updating while a side is not driving. The block has no reset; storage becomes defined after the first transparent phase or the first qualifying clock edge.

Top module: `bus_xcvr`

## Requirements
- R1: The data width is the parameter DATA_W, default 18. The two directions share no state: activity on one path never changes the other path's output.
- R2: While a path's latch enable is high, its output data equals its input data in the same cycle, whatever its clock or clock enable does.
- R3: While the latch enable is low and the clock enable (active low) is 0, a rising edge of the path clock loads the input. The output shows the loaded value directly after that edge.
- R4: While the latch enable is low and the path clock does not rise, input changes have no effect on the output.
- R5: While the clock enable is 1, rising clock edges are ignored and the output keeps its value.
- R6: When the latch enable falls, the path keeps the last value that passed through transparently until a qualifying clock edge arrives.
- R7: With the output enable (active low) at 1, the output-valid flag is 0 and, with MASK_IDLE=1 (the default), the output data is all zeros. With the enable at 0, the flag is 1 and the stored or transparent value is driven.
- R8: Loading and transparency continue while the output is disabled. Re-enabling the output shows the value stored during the disabled time.
- R9: The B-to-A path behaves exactly as the A-to-B path, using its own four controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | DATA_W | Data arriving from bus A |
| a_out | output | DATA_W | Data driven onto bus A (B-to-A path) |
| a_oe | output | 1 | High when a_out is actively driven |
| b_in | input | DATA_W | Data arriving from bus B |
| b_out | output | DATA_W | Data driven onto bus B (A-to-B path) |
| b_oe | output | 1 | High when b_out is actively driven |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_clk | input | 1 | A-to-B path clock, loads on rising edge |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_clk | input | 1 | B-to-A path clock, loads on rising edge |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |

## Verification
A wrong storage state shows at the output as soon as the latch enable is low and the output enable is low. Examples are a source selector stuck on the transparent copy, or an edge loaded while the clock enable was high. The error appears in the first sample after the faulty edge or after the latch enable falls. Errors made while the output is disabled stay hidden until the enable returns, so the bench re-enables the output after a disabled load and compares the value. Driving one path and then reading the other exposes any sharing between the two directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   localparam int unsigned XCVR_DEF_W = 18;
   localparam int unsigned XCVR_NDIR  = 2;

   typedef enum logic [0:0] {
      DIR_A2B = 1'b0,
      DIR_B2A = 1'b1
   } xcvr_dir_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         le,
   input  logic         ce_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] lat_q;
   logic [W-1:0] reg_q;
   logic         use_lat;

   // level-sensitive copy: follows d while le is high
   always_latch begin
      if (le) lat_q <= d;
   end

   // edge-triggered copy: loads only with le low and clock enabled
   always_ff @(posedge clk) begin
      if (!le && !ce_n) reg_q <= d;
   end

   // selects which copy is newest: transparency wins immediately,
   // a qualifying edge hands ownership to the register
   always_ff @(posedge clk or posedge le) begin
      if (le)         use_lat <= 1'b1;
      else if (!ce_n) use_lat <= 1'b0;
   end

   assign q = le ? d : (use_lat ? lat_q : reg_q);

   // R3: a qualifying edge leaves the register holding the sampled input
   p_capture_r3: assert property (@(posedge clk) disable iff (le)
      !ce_n |=> (reg_q == $past(d)));

   // R5: with the clock disabled the register does not move
   p_ce_block_r5: assert property (@(posedge clk) disable iff (le)
      ce_n |=> $stable(reg_q));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
   parameter int unsigned W         = 18,
   parameter bit          MASK_IDLE = 1'b1
) (
   input  logic         oe_n,
   input  logic [W-1:0] val,
   output logic [W-1:0] out,
   output logic         oe
);
   assign oe = ~oe_n;

   generate
      if (MASK_IDLE) begin : g_mask
         assign out = oe_n ? '0 : val;
      end else begin : g_pass
         assign out = val;
      end
   endgenerate
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned DATA_W    = XCVR_DEF_W,
   parameter bit          MASK_IDLE = 1'b1
) (
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   input  logic              ab_oe_n,
   input  logic              ab_le,
   input  logic              ab_clk,
   input  logic              ab_ce_n,
   input  logic              ba_oe_n,
   input  logic              ba_le,
   input  logic              ba_clk,
   input  logic              ba_ce_n
);
   localparam int unsigned ND = XCVR_NDIR;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bus_xcvr: DATA_W must be at least 1");
      end
   endgenerate

   logic [ND-1:0]     oe_n_v, le_v, clk_v, ce_n_v, oe_v;
   logic [DATA_W-1:0] din   [ND];
   logic [DATA_W-1:0] held  [ND];
   logic [DATA_W-1:0] dout  [ND];

   assign oe_n_v[DIR_A2B] = ab_oe_n;
   assign le_v  [DIR_A2B] = ab_le;
   assign clk_v [DIR_A2B] = ab_clk;
   assign ce_n_v[DIR_A2B] = ab_ce_n;
   assign din   [DIR_A2B] = a_in;
   assign oe_n_v[DIR_B2A] = ba_oe_n;
   assign le_v  [DIR_B2A] = ba_le;
   assign clk_v [DIR_B2A] = ba_clk;
   assign ce_n_v[DIR_B2A] = ba_ce_n;
   assign din   [DIR_B2A] = b_in;

   assign b_out = dout[DIR_A2B];
   assign b_oe  = oe_v[DIR_A2B];
   assign a_out = dout[DIR_B2A];
   assign a_oe  = oe_v[DIR_B2A];

   generate
      for (genvar g = 0; g < ND; g++) begin : g_path
         xcvr_store #(.W(DATA_W)) u_store (
            .clk  (clk_v[g]),
            .le   (le_v[g]),
            .ce_n (ce_n_v[g]),
            .d    (din[g]),
            .q    (held[g])
         );
         xcvr_drive #(.W(DATA_W), .MASK_IDLE(MASK_IDLE)) u_drive (
            .oe_n (oe_n_v[g]),
            .val  (held[g]),
            .out  (dout[g]),
            .oe   (oe_v[g])
         );

         // R2: an enabled transparent path shows its input at the far bus
         p_transp_r2: assert property (@(posedge clk_v[g]) disable iff (oe_n_v[g])
            le_v[g] |-> (dout[g] == din[g]));

         // R7: the valid flag tracks the output enable seen at a clock edge
         p_oe_flag_r7: assert property (@(posedge clk_v[g])
            oe_n_v[g] |-> !oe_v[g]);
      end
   endgenerate
endmodule

// File: tb/bus_xcvr_tb.sv
module bus_xcvr_tb;
   localparam int W  = 18;
   localparam int NV = 12;

   typedef struct packed {
      logic          oe_n;
      logic          le;
      logic          ce_n;
      logic          pulse;
      logic [W-1:0]  data;
      logic          exp_oe;
      logic [W-1:0]  exp_out;
   } vec_t;

   // per step: controls, data, then expected valid flag and output
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,1'b0,1'b0,18'h15555,1'b1,18'h15555},
      '{1'b0,1'b1,1'b0,1'b0,18'h2AAAA,1'b1,18'h2AAAA},
      '{1'b0,1'b0,1'b0,1'b0,18'h00F0F,1'b1,18'h2AAAA},
      '{1'b0,1'b0,1'b0,1'b1,18'h00F0F,1'b1,18'h00F0F},
      '{1'b0,1'b0,1'b0,1'b0,18'h3FFFF,1'b1,18'h00F0F},
      '{1'b0,1'b0,1'b1,1'b1,18'h12345,1'b1,18'h00F0F},
      '{1'b0,1'b0,1'b0,1'b1,18'h12345,1'b1,18'h12345},
      '{1'b1,1'b0,1'b0,1'b1,18'h0ABCD,1'b0,18'h00000},
      '{1'b0,1'b0,1'b0,1'b0,18'h0ABCD,1'b1,18'h0ABCD},
      '{1'b0,1'b1,1'b1,1'b1,18'h3C3C3,1'b1,18'h3C3C3},
      '{1'b1,1'b1,1'b1,1'b0,18'h00001,1'b0,18'h00000},
      '{1'b0,1'b0,1'b1,1'b0,18'h00002,1'b1,18'h00001}
   };
   localparam string TAG [NV] = '{"R2","R2","R6","R3","R4","R5",
                                  "R3","R7","R8","R2","R7","R6"};

   logic         clk = 1'b0;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic         a_oe, b_oe;
   logic         ab_oe_n, ab_le, ab_clk, ab_ce_n;
   logic         ba_oe_n, ba_le, ba_clk, ba_ce_n;
   int           checks = 0;
   int           fails  = 0;
   int           cycles = 0;
   bit           done   = 1'b0;

   always #2.5 clk = ~clk;

   bus_xcvr u_dut (
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n)
   );

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   task automatic set_ctl(input bit dir, input logic oe_n, input logic le,
                          input logic ce_n);
      if (!dir) begin ab_oe_n = oe_n; ab_le = le; ab_ce_n = ce_n; end
      else      begin ba_oe_n = oe_n; ba_le = le; ba_ce_n = ce_n; end
   endtask

   task automatic set_data(input bit dir, input logic [W-1:0] v);
      if (!dir) a_in = v; else b_in = v;
   endtask

   task automatic pulse(input bit dir);
      if (!dir) ab_clk = 1'b1; else ba_clk = 1'b1;
      @(negedge clk);
      if (!dir) ab_clk = 1'b0; else ba_clk = 1'b0;
   endtask

   // controls first, data one half-cycle later, then an optional edge
   task automatic walk(input bit dir);
      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         set_ctl(dir, VEC[i].oe_n, VEC[i].le, VEC[i].ce_n);
         @(negedge clk);
         set_data(dir, VEC[i].data);
         @(posedge clk);
         if (VEC[i].pulse) pulse(dir);
         @(negedge clk);
         check({TAG[i], dir ? "/R9" : ""},
               dir ? W'(a_oe) : W'(b_oe), W'(VEC[i].exp_oe));
         check({TAG[i], dir ? "/R9" : ""},
               dir ? a_out : b_out, VEC[i].exp_out);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
         summary();
      end
   end

   initial begin
      a_in = '0; b_in = '0;
      ab_clk = 1'b0; ba_clk = 1'b0;
      set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
      set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
      repeat (2) @(negedge clk);
      // R7: both sides start disabled, masked to zero
      check("R7", W'(b_oe), '0);
      check("R7", a_out, '0);
      walk(1'b0);
      walk(1'b1);
      // R1: B-to-A activity left the A-to-B result untouched
      check("R1", b_out, 18'h00001);
      set_data(1'b0, 18'h3FFFF);
      pulse(1'b0);
      @(negedge clk);
      // R1: A-to-B input ignored (clock disabled) and B-to-A unaffected
      check("R1", a_out, 18'h00001);
      check("R1", b_out, 18'h00001);
      done = 1'b1;
      summary();
   end
endmodule